// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block decides whether a received Ethernet frame is kept or discarded by looking only at its 48-bit destination address. On a one-cycle `frame_start` strobe it samples the address and the filter controls. One clock later it presents an accept/drop verdict and a code that says which rule matched. Two tables are loaded through a simple word-write port. The first is a small set of exact-match address entries, each of which is used only while its enable bit is set. The second is a multicast hash table of 64, 128 or 256 bins, sized at build time.

The hash bin of an address is found as follows. Take the reflected CRC-32 over the six address bytes, starting from all ones, first byte first and least significant bit first. Invert it and reverse its bits. The bin is the top n bits of that value. The control inputs select which paths are used: promiscuous reception, passing of control-reserved frames, acceptance of any group address, hash filtering of group addresses, OR-ing of exact and hash matches, rejection of broadcast, and a receive-all override.

Top module: `rx_addr_filter`

## Requirements
- R1: Reset clears `accept_valid`, disables every exact-match entry and clears the hash table. Until the tables are loaded, a unicast frame is dropped with match code 0 (none).
- R2: `accept_valid` is high for exactly the one cycle that follows a cycle with `frame_start` high, and is low otherwise.
- R3: Exact entry e is written at word address 2e+1 (address bytes 0..3, byte 0 in bits 7:0) and at word address 2e (bytes 4..5 in bits 15:0, enable in bit 31). An enabled entry equal to the address gives match code 1. A disabled entry never matches.
- R4: Bit k of the hash index is bit (n-1-k) of the inverted CRC described above. Hash word w (address 16+w) holds bins 32w..32w+31, with bin b at bit b mod 32. A group address that hits a set bin while hash filtering is on is accepted with match code 2.
- R5: While hash filtering is on, an exact match on a group address counts only if `cfg_hash_or_perfect` is set. While hash filtering is off, exact matches on group addresses count. Exact matches on unicast addresses always count.
- R6: With `cfg_pass_mcast`, any non-broadcast group address (bit 0 of byte 0 set) that no earlier rule claims is accepted with match code 4.
- R7: The all-ones broadcast address is accepted with match code 3 unless `cfg_bcast_dis` is set. When it is set, broadcast is dropped unless another rule accepts it.
- R8: `cfg_promisc` accepts any frame that no other rule claims, with match code 5. Rules that do match still report their own code.
- R9: The control-reserved address 01-80-C2-00-00-01 always reports match code 6. It is accepted only when `cfg_pass_ctrl` is set, even under promiscuous mode.
- R10: `cfg_rx_all` forces `accept` high, and the match code is still reported unchanged.
- R11: A write to the word address of an exact entry at or beyond NUM_PERFECT has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table word write strobe |
| wr_addr | input | 5 | Word address: 0..15 exact entries, 16..23 hash words |
| wr_data | input | 32 | Word to write |
| frame_start | input | 1 | One-cycle strobe; address and controls are sampled with it |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| cfg_promisc | input | 1 | Promiscuous reception |
| cfg_pass_ctrl | input | 1 | Let control-reserved frames through |
| cfg_pass_mcast | input | 1 | Accept every group address |
| cfg_hash_mc | input | 1 | Filter group addresses through the hash table |
| cfg_hash_or_perfect | input | 1 | Let exact matches pass group addresses while hashing |
| cfg_bcast_dis | input | 1 | Reject broadcast |
| cfg_rx_all | input | 1 | Force acceptance |
| accept_valid | output | 1 | Verdict valid, one cycle after the strobe |
| accept | output | 1 | Keep the frame |
| match_type | output | 3 | 0 none, 1 exact, 2 hash, 3 broadcast, 4 all-group, 5 promiscuous, 6 control |

## Verification
The assertions rely on three conditions. `dest_addr` and all `cfg_*` inputs must be known whenever `frame_start` is high. `frame_start` must be a clean level that is low after reset. Tables should not be rewritten in the same cycle as a strobe whose verdict depends on them. The bench drives every input on the falling edge, so each strobe, address and control set is stable across the sampling edge. It performs table writes in separate cycles before the frames that use them. Hash coverage uses indices computed by an independent byte-wise CRC model; that model is first checked against the standard check value.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int HASH_BITS   = 6,
  parameter int NUM_PERFECT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        frame_start,
  input  logic [47:0] dest_addr,
  input  logic        cfg_promisc,
  input  logic        cfg_pass_ctrl,
  input  logic        cfg_pass_mcast,
  input  logic        cfg_hash_mc,
  input  logic        cfg_hash_or_perfect,
  input  logic        cfg_bcast_dis,
  input  logic        cfg_rx_all,
  output logic        accept_valid,
  output logic        accept,
  output logic [2:0]  match_type
);
  localparam int HASH_SIZE  = 1 << HASH_BITS;
  localparam int HASH_WORDS = HASH_SIZE / 32;
  localparam logic [47:0] CTRL_ADDR = 48'h01_00_00_C2_80_01;

  localparam logic [2:0] MT_NONE = 3'd0, MT_PERF = 3'd1, MT_HASH = 3'd2,
                         MT_BCST = 3'd3, MT_MALL = 3'd4, MT_PROM = 3'd5,
                         MT_CTRL = 3'd6;

  logic [47:0]            pa_addr [NUM_PERFECT];
  logic [NUM_PERFECT-1:0] pa_en;
  logic [HASH_SIZE-1:0]   htab;

  function automatic logic [HASH_BITS-1:0] hash_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    for (int k = 0; k < HASH_BITS; k++) hash_idx[k] = ~c[HASH_BITS-1-k];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_en <= '0;
      htab  <= '0;
      for (int e = 0; e < NUM_PERFECT; e++) pa_addr[e] <= '0;
    end else if (wr_en) begin
      if (!wr_addr[4]) begin
        for (int e = 0; e < NUM_PERFECT; e++) begin
          if (wr_addr[3:1] == 3'(e)) begin
            if (wr_addr[0]) pa_addr[e][31:0] <= wr_data;
            else begin
              pa_addr[e][47:32] <= wr_data[15:0];
              pa_en[e]          <= wr_data[31];
            end
          end
        end
      end else begin
        for (int w = 0; w < HASH_WORDS; w++)
          if (wr_addr[2:0] == 3'(w)) htab[w*32 +: 32] <= wr_data;
      end
    end
  end

  logic perf_hit;
  always_comb begin
    perf_hit = 1'b0;
    for (int e = 0; e < NUM_PERFECT; e++)
      if (pa_en[e] && pa_addr[e] == dest_addr) perf_hit = 1'b1;
  end

  wire is_group = dest_addr[0];
  wire is_bcast = &dest_addr;
  wire is_ctrl  = dest_addr == CTRL_ADDR;
  wire hash_hit = htab[hash_idx(dest_addr)];
  wire perf_ok  = perf_hit && (!is_group || !cfg_hash_mc || cfg_hash_or_perfect);

  logic [2:0] mt_d;
  always_comb begin
    if (is_ctrl)                                   mt_d = MT_CTRL;
    else if (is_bcast && !cfg_bcast_dis)           mt_d = MT_BCST;
    else if (perf_ok)                              mt_d = MT_PERF;
    else if (is_group && !is_bcast && cfg_hash_mc && hash_hit) mt_d = MT_HASH;
    else if (is_group && !is_bcast && cfg_pass_mcast)          mt_d = MT_MALL;
    else if (cfg_promisc)                          mt_d = MT_PROM;
    else                                           mt_d = MT_NONE;
  end

  wire acc_d = cfg_rx_all || (is_ctrl ? cfg_pass_ctrl : (mt_d != MT_NONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_valid <= 1'b0;
      accept       <= 1'b0;
      match_type   <= MT_NONE;
    end else begin
      accept_valid <= frame_start;
      if (frame_start) begin
        accept     <= acc_d;
        match_type <= mt_d;
      end
    end
  end

  assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> accept_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> !accept_valid);
  assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_valid |-> match_type <= MT_CTRL);
  assert_drop_has_no_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_valid && !accept) |-> (match_type == MT_NONE || match_type == MT_CTRL));
  assert_bcast_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (&dest_addr) && !cfg_bcast_dis) |=> (accept && match_type == MT_BCST));
  assert_promisc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_promisc && dest_addr != CTRL_ADDR) |=> accept);
  assert_ctrl_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && dest_addr == CTRL_ADDR && !cfg_pass_ctrl && !cfg_rx_all) |=> !accept);
  assert_rx_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_rx_all) |=> accept);
endmodule

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/100ps
module rx_addr_filter_tb;
  localparam int HB = 6;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic frame_start = 1'b0;
  logic [47:0] dest_addr = '0;
  logic [6:0] cfg = '0;
  logic accept_valid, accept;
  logic [2:0] match_type;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rx_addr_filter #(.HASH_BITS(HB), .NUM_PERFECT(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .dest_addr(dest_addr),
    .cfg_promisc(cfg[6]), .cfg_pass_ctrl(cfg[5]), .cfg_pass_mcast(cfg[4]),
    .cfg_hash_mc(cfg[3]), .cfg_hash_or_perfect(cfg[2]), .cfg_bcast_dis(cfg[1]),
    .cfg_rx_all(cfg[0]),
    .accept_valid(accept_valid), .accept(accept), .match_type(match_type));

  localparam logic [47:0] STA = 48'h5544_3322_1102;
  localparam logic [47:0] MP  = 48'hFB00_005E_0001;
  localparam logic [47:0] DIS = 48'h6655_4433_AA02;
  localparam logic [47:0] UNK = 48'h0102_0304_0506;
  localparam logic [47:0] UMC = 48'h0000_005E_0001;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] CTL = 48'h0100_00C2_8001;

  // {address, cfg {promisc,pass_ctrl,pass_mcast,hash_mc,hash_or_perfect,bcast_dis,rx_all}, accept, code}
  localparam int NV = 19;
  localparam logic [58:0] VEC [NV] = '{
    {STA, 7'b0000000, 1'b1, 3'd1},  // R3
    {UNK, 7'b0000000, 1'b0, 3'd0},  // R3
    {DIS, 7'b0000000, 1'b0, 3'd0},  // R3 disabled entry
    {MP,  7'b0000000, 1'b1, 3'd1},  // R5 hash off
    {MP,  7'b0001000, 1'b0, 3'd0},  // R5 hash only
    {MP,  7'b0001100, 1'b1, 3'd1},  // R5 hash-or-perfect
    {UMC, 7'b0010000, 1'b1, 3'd4},  // R6
    {UMC, 7'b0000000, 1'b0, 3'd0},  // R6
    {BC,  7'b0000000, 1'b1, 3'd3},  // R7
    {BC,  7'b0000010, 1'b0, 3'd0},  // R7
    {BC,  7'b1000010, 1'b1, 3'd5},  // R7 R8
    {UNK, 7'b1000000, 1'b1, 3'd5},  // R8
    {STA, 7'b1000000, 1'b1, 3'd1},  // R8
    {CTL, 7'b1000000, 1'b0, 3'd6},  // R9
    {CTL, 7'b0100000, 1'b1, 3'd6},  // R9
    {UNK, 7'b0000001, 1'b1, 3'd0},  // R10
    {CTL, 7'b0000001, 1'b1, 3'd6},  // R10
    {STA, 7'b0001000, 1'b1, 3'd1},  // R5 unicast exact ignores hash mode
    {UMC, 7'b0011000, 1'b1, 3'd4}   // R6 hash miss falls to all-group
  };

  function automatic logic [31:0] crc_raw(input logic [71:0] bytes, input int nbytes);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < nbytes; b++) begin
      c = c ^ {24'd0, bytes[b*8 +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic int ref_idx(input logic [47:0] a);
    logic [31:0] inv, rev;
    inv = ~crc_raw({24'd0, a}, 6);
    for (int i = 0; i < 32; i++) rev[i] = inv[31-i];
    return int'(rev >> (32 - HB));
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {acc,code}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_entry(input int e, input logic [47:0] a, input logic en);
    wreg(5'(2*e + 1), a[31:0]);
    wreg(5'(2*e), {en, 15'd0, a[47:32]});
  endtask

  task automatic send(input logic [47:0] a, input logic [6:0] c, input string tag,
                      input logic exp_acc, input logic [2:0] exp_mt);
    @(negedge clk);
    frame_start = 1'b1; dest_addr = a; cfg = c;
    @(negedge clk);
    frame_start = 1'b0;
    check(tag, {accept_valid ? accept : 1'bx, match_type}, {exp_acc, exp_mt});
    if (!accept_valid) begin
      fails++;
      $display("FAIL R2: actual accept_valid=0 expected 1");
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {3'd0, accept_valid}, 4'd0);
    rst_n = 1'b1;
    send(STA, 7'b0, "R1 empty table drop", 1'b0, 3'd0);

    @(negedge clk);
    check("R2 single-cycle valid", {3'd0, accept_valid}, 4'd0);

    set_entry(0, STA, 1'b1);
    set_entry(1, MP, 1'b1);
    set_entry(2, DIS, 1'b0);
    set_entry(5, UNK, 1'b1);  // beyond NUM_PERFECT
    send(UNK, 7'b0, "R11 out-of-range entry write ignored", 1'b0, 3'd0);

    for (int v = 0; v < NV; v++)
      send(VEC[v][58:11], VEC[v][10:4], $sformatf("vector %0d (R3..R10)", v),
           VEC[v][3], VEC[v][2:0]);

    checks++;
    if (~crc_raw(72'h39_38_37_36_35_34_33_32_31, 9) !== 32'hCBF4_3926) begin
      fails++;
      $display("FAIL R4: model check value actual %h expected cbf43926",
               ~crc_raw(72'h39_38_37_36_35_34_33_32_31, 9));
    end

    for (int k = 0; k < 8; k++) begin
      logic [47:0] a;
      int idx;
      a = {8'(k * 37 + 5), 8'(k), 8'h5E ^ 8'(k * 3), 8'h00, 8'h00, 8'h01 | 8'(k << 2)};
      idx = ref_idx(a);
      for (int w = 0; w < (1 << HB) / 32; w++) wreg(5'(16 + w), 32'd0);
      wreg(5'(16 + idx / 32), 32'd1 << (idx % 32));
      send(a, 7'b0001000, $sformatf("R4 hash hit bin %0d", idx), 1'b1, 3'd2);
      wreg(5'(16 + idx / 32), 32'd0);
      wreg(5'(16 + (idx ^ 1) / 32), 32'd1 << ((idx ^ 1) % 32));
      send(a, 7'b0001000, $sformatf("R4 neighbour bin %0d miss", idx ^ 1), 1'b0, 3'd0);
      wreg(5'(16 + (idx ^ 1) / 32), 32'd0);
    end

    report();
    $finish;
  end
endmodule